// File: doc/BRIEF.md
# Slot-Priority Interrupt Controller

This block gathers thirty-two internal interrupt sources and eight external pins. It picks the single most urgent request that is both pending and enabled, and reports it to the processor as a 7-bit vector together with one request line. The internal sources are split into four groups of eight, called A to D. Software ranks the members of each group by writing member codes into eight ordered 3-bit slot fields. A separate override field lifts one chosen source above every other source.

Each external pin can sense either an active-low level or a falling edge. In edge mode the pin sets a pending flag, which software clears through the pending register. Software reaches all of this state through a flat 32-bit word-addressed register port with a write strobe. Reads are combinational and return data in the same cycle.

The output stage is a two-state machine. ST_IDLE moves to ST_ACTIVE (transition T_RAISE) when the resolved candidate vector is nonzero. ST_ACTIVE moves back to ST_IDLE (transition T_DROP) when the candidate becomes zero. In every other case the state holds. The request line is high in ST_ACTIVE, and the vector register is loaded on the same clock edge as the state register.

Top module: `spic_top`

## Requirements
- R1: The internal and external enable registers number their sources MSB-first. Internal source n uses bit 31-n of address 1, and external pin k uses bit 31-k of address 2. A 1 enables the source and a 0 blocks it.
- R2: After reset, both enable registers, the sense register and the override field read 0. Each group priority register reads with slot p holding member p. The vector is 0 and irq_o is low, even when every source is asserted.
- R3: Internal sources are active-low level inputs. Internal source n reports vector 32+n, and external pin k reports vector 16+k.
- R4: In the sense register (address 3), pin k uses bit 15-k. A 1 selects falling-edge sensing and a 0 selects low-level sensing.
- R5: An edge-sensed pin sets a pending flag on each falling edge, and the flag stays set after the pin returns high. Writing 1 at bit 31-k of address 4 clears the flag for pin k, and writing 0 leaves it unchanged. A falling edge in the same cycle as a clear wins over the clear. In level mode the flag is held at 0.
- R6: A read of address 4 returns, at bit 31-k, the edge flag of an edge-sensed pin or the current asserted state of a level-sensed pin. Writes do not affect a level-sensed pin.
- R7: Group g (A=0 to D=3) is ranked by the register at address 8+g. Slot p for p=0..3 sits at bits [22+(3-p)*3 : 20+(3-p)*3], and slot p for p=4..7 sits at bits [6+(7-p)*3 : 4+(7-p)*3]. Slot 0 has the highest priority. Bits outside the slot fields read 0.
- R8: If one member code appears in several slots, the lowest-numbered slot sets its rank. Members listed in no slot rank below all listed members, in ascending index order.
- R9: Enabled pending external pins rank above all internal groups, with pin 0 first. Among the groups, A beats B, B beats C and C beats D.
- R10: The override field, bits 30:24 of address 0, names a vector number. When that source is pending and enabled, it wins over all other ordering. Otherwise the field has no effect.
- R11: Address 5 returns the current vector in its low 7 bits, and 0 means nothing is pending.
- R12: irq_o is high exactly when the vector is nonzero. Both irq_o and the vector register follow a change of an input, enable or priority one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_int_n | input | 32 | Internal sources, active low, source n on bit n |
| irq_ext_n | input | 8 | External pins, active low, pin k on bit k |
| vec_o | output | 7 | Registered winning vector, 0 when idle |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench runs several hundred pseudo-random configurations and compares each result with its own rank model. Each configuration sets the enables, four random slot words full of duplicate codes and missing members, the override value (valid, stale or out of range) and the asserted sources. A design that took the last duplicate slot instead of the first, ranked unlisted members wrongly or swapped the group order would return a different vector. A walk over every source position in both enable registers catches a bit order that runs the wrong way. A walk over every pin in edge mode shows whether a flag survives the pin's release, ignores zero writes and clears only on a 1. The same walk shows whether level pins resist clearing. The request timing is sampled just before and just after the clock edge that follows an input change, which exposes an output that is combinational or one cycle late.

// File: rtl/spic_pkg.sv
package spic_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int VEC_W     = 7;
    localparam int MEMB_W    = 3;
    localparam int GRP_SIZE  = 1 << MEMB_W;
    localparam int NUM_GRP   = 4;
    localparam int NUM_INT   = NUM_GRP * GRP_SIZE;
    localparam int NUM_EXT   = 8;
    localparam int EXT_BASE  = 16;
    localparam int INT_BASE  = 32;

    localparam logic [ADDR_W-1:0] A_CFG   = 4'd0;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'd1;
    localparam logic [ADDR_W-1:0] A_EEN   = 4'd2;
    localparam logic [ADDR_W-1:0] A_SENSE = 4'd3;
    localparam logic [ADDR_W-1:0] A_PEND  = 4'd4;
    localparam logic [ADDR_W-1:0] A_VEC   = 4'd5;
    localparam logic [ADDR_W-1:0] A_PRIO  = 4'd8;

    localparam int OVR_LSB = 24;
    localparam int SENSE_TOP = 15;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } irq_state_e;

    // lowest bit of slot field p inside a group priority word
    function automatic int slot_lsb(input int p);
        return (p < 4) ? (20 + (3 - p) * 3) : (4 + (7 - p) * 3);
    endfunction

    // bits that hold slot fields
    function automatic logic [DATA_W-1:0] slot_keep();
        logic [DATA_W-1:0] w;
        w = '0;
        for (int p = 0; p < GRP_SIZE; p++)
            w[slot_lsb(p) +: MEMB_W] = '1;
        return w;
    endfunction

    // identity ordering: slot p holds member p
    function automatic logic [DATA_W-1:0] slot_identity();
        logic [DATA_W-1:0] w;
        w = '0;
        for (int p = 0; p < GRP_SIZE; p++)
            w[slot_lsb(p) +: MEMB_W] = MEMB_W'(p);
        return w;
    endfunction

endpackage

// File: rtl/spic_regfile.sv
module spic_regfile
    import spic_pkg::*;
#(
    parameter int N_GRP = NUM_GRP,
    parameter int N_EXT = NUM_EXT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    input  logic [N_EXT-1:0]        irq_ext_n,
    input  logic [VEC_W-1:0]        vec_q,
    output logic [DATA_W-1:0]       int_mask,
    output logic [N_EXT-1:0]        ext_en,
    output logic [N_EXT-1:0]        ext_pend,
    output logic [VEC_W-1:0]        ovr_vec,
    output logic [N_GRP-1:0][DATA_W-1:0] prio_word
);

    localparam logic [DATA_W-1:0] KEEP  = slot_keep();
    localparam logic [DATA_W-1:0] IDENT = slot_identity();

    logic [N_EXT-1:0] edge_sel;
    logic [N_EXT-1:0] ext_prev;
    logic [N_EXT-1:0] edge_flag;
    logic [N_EXT-1:0] edge_flag_d;
    logic [N_EXT-1:0] fall;
    logic             pend_wr;

    assign pend_wr = wr_en && (addr == A_PEND);
    assign fall    = ext_prev & ~irq_ext_n;

    always_comb begin
        for (int k = 0; k < N_EXT; k++) begin
            if (edge_sel[k])
                edge_flag_d[k] = (edge_flag[k] & ~(pend_wr & wdata[DATA_W-1-k])) | fall[k];
            else
                edge_flag_d[k] = 1'b0;
            ext_pend[k] = edge_sel[k] ? edge_flag[k] : ~irq_ext_n[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_vec   <= '0;
            int_mask  <= '0;
            ext_en    <= '0;
            edge_sel  <= '0;
            edge_flag <= '0;
            ext_prev  <= '1;
            for (int g = 0; g < N_GRP; g++)
                prio_word[g] <= IDENT;
        end else begin
            ext_prev  <= irq_ext_n;
            edge_flag <= edge_flag_d;
            if (wr_en) begin
                if (addr == A_CFG)
                    ovr_vec <= wdata[OVR_LSB +: VEC_W];
                if (addr == A_IEN)
                    int_mask <= wdata;
                for (int k = 0; k < N_EXT; k++) begin
                    if (addr == A_EEN)
                        ext_en[k] <= wdata[DATA_W-1-k];
                    if (addr == A_SENSE)
                        edge_sel[k] <= wdata[SENSE_TOP-k];
                end
                for (int g = 0; g < N_GRP; g++)
                    if (addr == A_PRIO + ADDR_W'(g))
                        prio_word[g] <= wdata & KEEP;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG:   rdata[OVR_LSB +: VEC_W] = ovr_vec;
            A_IEN:   rdata = int_mask;
            A_VEC:   rdata[VEC_W-1:0] = vec_q;
            default: rdata = '0;
        endcase
        for (int k = 0; k < N_EXT; k++) begin
            if (addr == A_EEN)   rdata[DATA_W-1-k] = ext_en[k];
            if (addr == A_SENSE) rdata[SENSE_TOP-k] = edge_sel[k];
            if (addr == A_PEND)  rdata[DATA_W-1-k] = ext_pend[k];
        end
        for (int g = 0; g < N_GRP; g++)
            if (addr == A_PRIO + ADDR_W'(g))
                rdata = prio_word[g];
    end

endmodule

// File: rtl/spic_group_arb.sv
module spic_group_arb
    import spic_pkg::*;
#(
    parameter int MEMBERS = GRP_SIZE,
    localparam int MW     = $clog2(MEMBERS)
) (
    input  logic [MEMBERS-1:0] req,
    input  logic [DATA_W-1:0]  slots,
    output logic               hit,
    output logic [MW-1:0]      member
);

    logic [MEMBERS-1:0] listed;
    logic [MW-1:0]      code;

    always_comb begin
        listed = '0;
        hit    = 1'b0;
        member = '0;
        // slot scan: first slot whose member is requesting wins
        for (int p = 0; p < MEMBERS; p++) begin
            code = slots[slot_lsb(p) +: MW];
            listed[code] = 1'b1;
            if (!hit && req[code]) begin
                hit    = 1'b1;
                member = code;
            end
        end
        // members absent from every slot, ascending index
        for (int m = 0; m < MEMBERS; m++) begin
            if (!hit && req[m] && !listed[m]) begin
                hit    = 1'b1;
                member = MW'(m);
            end
        end
    end

endmodule

// File: rtl/spic_top.sv
module spic_top
    import spic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [31:0]       irq_int_n,
    input  logic [7:0]        irq_ext_n,
    output logic [6:0]        vec_o,
    output logic              irq_o
);

    localparam int EXT_IW = $clog2(NUM_EXT);
    localparam int INT_IW = $clog2(NUM_INT);

    logic [DATA_W-1:0]              int_mask;
    logic [NUM_EXT-1:0]             ext_en;
    logic [NUM_EXT-1:0]             ext_pend;
    logic [VEC_W-1:0]               ovr_vec;
    logic [NUM_GRP-1:0][DATA_W-1:0] prio_word;
    logic [NUM_INT-1:0]             int_req;
    logic [NUM_EXT-1:0]             ext_req;
    logic [NUM_GRP-1:0]             grp_hit;
    logic [NUM_GRP-1:0][MEMB_W-1:0] grp_member;
    logic [VEC_W-1:0]               cand;
    logic [VEC_W-1:0]               vec_q;
    logic [VEC_W-1:0]               ovr_off_e;
    logic [VEC_W-1:0]               ovr_off_i;
    irq_state_e                     state_q;
    irq_state_e                     state_d;

    spic_regfile #(.N_GRP(NUM_GRP), .N_EXT(NUM_EXT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_ext_n (irq_ext_n),
        .vec_q     (vec_q),
        .int_mask  (int_mask),
        .ext_en    (ext_en),
        .ext_pend  (ext_pend),
        .ovr_vec   (ovr_vec),
        .prio_word (prio_word)
    );

    always_comb begin
        for (int n = 0; n < NUM_INT; n++)
            int_req[n] = ~irq_int_n[n] & int_mask[DATA_W-1-n];
        for (int k = 0; k < NUM_EXT; k++)
            ext_req[k] = ext_pend[k] & ext_en[k];
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        spic_group_arb #(.MEMBERS(GRP_SIZE)) u_arb (
            .req    (int_req[g*GRP_SIZE +: GRP_SIZE]),
            .slots  (prio_word[g]),
            .hit    (grp_hit[g]),
            .member (grp_member[g])
        );
    end

    assign ovr_off_e = ovr_vec - VEC_W'(EXT_BASE);
    assign ovr_off_i = ovr_vec - VEC_W'(INT_BASE);

    // candidate: override, then pins, then groups A..D
    always_comb begin
        cand = '0;
        for (int g = NUM_GRP - 1; g >= 0; g--)
            if (grp_hit[g])
                cand = VEC_W'(INT_BASE + g * GRP_SIZE) + VEC_W'(grp_member[g]);
        for (int k = NUM_EXT - 1; k >= 0; k--)
            if (ext_req[k])
                cand = VEC_W'(EXT_BASE + k);
        if (ovr_vec >= VEC_W'(EXT_BASE) && ovr_vec < VEC_W'(EXT_BASE + NUM_EXT)
            && ext_req[ovr_off_e[EXT_IW-1:0]])
            cand = ovr_vec;
        if (ovr_vec >= VEC_W'(INT_BASE) && ovr_vec < VEC_W'(INT_BASE + NUM_INT)
            && int_req[ovr_off_i[INT_IW-1:0]])
            cand = ovr_vec;
    end

    // state transitions: T_RAISE and T_DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cand != '0) state_d = ST_ACTIVE;
            ST_ACTIVE: if (cand == '0) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= cand;
    end

    assign vec_o = vec_q;
    assign irq_o = (state_q == ST_ACTIVE);

endmodule

// File: rtl/spic_checker.sv
module spic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_o,
    input logic [6:0]  vec_o,
    input logic [31:0] int_mask,
    input logic [7:0]  ext_en,
    input logic [31:0] irq_int_n
);

    logic [31:0] mask_d;
    logic [7:0]  een_d;
    logic [31:0] irqn_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_d <= '0;
            een_d  <= '0;
            irqn_d <= '1;
        end else begin
            mask_d <= int_mask;
            een_d  <= ext_en;
            irqn_d <= irq_int_n;
        end
    end

    p_irq_iff_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec_o != 7'd0));

    p_quiet_when_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == 32'd0 && ext_en == 8'd0) |=> (vec_o == 7'd0));

    p_vec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o == 7'd0) || (vec_o >= 7'd16 && vec_o < 7'd24) || (vec_o >= 7'd32 && vec_o < 7'd64));

    p_int_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o >= 7'd32 && vec_o < 7'd64) |-> (mask_d[31 - (vec_o[4:0])] && !irqn_d[vec_o[4:0]]));

    p_ext_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o >= 7'd16 && vec_o < 7'd24) |-> een_d[vec_o[2:0]]);

endmodule

bind spic_top spic_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .vec_o     (vec_o),
    .int_mask  (int_mask),
    .ext_en    (ext_en),
    .irq_int_n (irq_int_n)
);

// File: tb/sim_spic_top.sv
`timescale 1ns/1ps
module sim_spic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [31:0] irq_int_n = '1;
    logic [7:0]  irq_ext_n = '1;
    logic [6:0]  vec_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] seed = 32'h1234_5678;

    logic [31:0]       sh_ien;
    logic [31:0]       sh_een;
    logic [3:0][31:0]  sh_prio;
    logic [6:0]        sh_ovr;

    always #2.5 clk = ~clk;

    spic_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_int_n(irq_int_n), .irq_ext_n(irq_ext_n),
        .vec_o(vec_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] rnd(inout logic [31:0] s);
        s = s ^ (s << 13);
        s = s ^ (s >> 17);
        s = s ^ (s << 5);
        return s;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; #0.5; d = rdata;
    endtask

    task automatic settle();
        @(posedge clk); @(posedge clk); @(negedge clk);
    endtask

    // rank model from the requirements
    function automatic logic [6:0] model(input logic [31:0] ien, input logic [31:0] een,
                                         input logic [7:0] epend, input logic [31:0] in_n,
                                         input logic [3:0][31:0] pw, input logic [6:0] ov);
        logic [31:0] ia;
        logic [7:0]  ea;
        int best, bm, r, lsb;
        for (int n = 0; n < 32; n++) ia[n] = !in_n[n] && ien[31-n];
        for (int k = 0; k < 8; k++)  ea[k] = epend[k] && een[31-k];
        if (ov >= 16 && ov < 24 && ea[ov-16]) return ov;
        if (ov >= 32 && ov < 64 && ia[ov-32]) return ov;
        for (int k = 0; k < 8; k++) if (ea[k]) return 7'(16 + k);
        for (int g = 0; g < 4; g++) begin
            best = 99; bm = 0;
            for (int m = 0; m < 8; m++) begin
                if (ia[g*8+m]) begin
                    r = 8 + m;
                    for (int p = 7; p >= 0; p--) begin
                        lsb = (p < 4) ? (20 + (3 - p) * 3) : (4 + (7 - p) * 3);
                        if (int'(pw[g][lsb +: 3]) == m) r = p;
                    end
                    if (r < best) begin best = r; bm = m; end
                end
            end
            if (best < 99) return 7'(32 + g*8 + bm);
        end
        return 7'd0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] ident;
        logic [7:0]  lvl;
        ident = '0;
        for (int p = 0; p < 8; p++)
            ident[(p < 4) ? (20 + (3 - p) * 3) : (4 + (7 - p) * 3) +: 3] = 3'(p);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset values
        rd(4'd0, d); chk(d, 32'd0, "R2 override reset");
        rd(4'd1, d); chk(d, 32'd0, "R2 internal enable reset");
        rd(4'd2, d); chk(d, 32'd0, "R2 external enable reset");
        rd(4'd3, d); chk(d, 32'd0, "R2 sense reset");
        rd(4'd4, d); chk(d, 32'd0, "R6 pending idle pins");
        for (int g = 0; g < 4; g++) begin
            rd(4'(8 + g), d); chk(d, ident, "R2 R7 identity slots");
        end
        irq_int_n = '0; irq_ext_n = '0;
        settle();
        chk({25'd0, vec_o}, 32'd0, "R2 all blocked vector");
        chk({31'd0, irq_o}, 32'd0, "R2 all blocked irq");
        irq_int_n = '1; irq_ext_n = '1;

        // R1 R3: walk each internal source
        for (int n = 0; n < 32; n++) begin
            wr(4'd1, 32'h8000_0000 >> n);
            irq_int_n = '0;
            settle();
            chk({25'd0, vec_o}, 32 + n, "R1 R3 single enabled source");
            rd(4'd5, d); chk(d, 32 + n, "R11 vector read");
            irq_int_n = '1;
            settle();
            chk({25'd0, vec_o}, 32'd0, "R3 high input inactive");
            wr(4'd1, ~(32'h8000_0000 >> n));
            irq_int_n = ~(32'd1 << n);
            settle();
            chk({25'd0, vec_o}, 32'd0, "R1 blocked source");
            irq_int_n = '1;
        end
        wr(4'd1, 32'd0);

        // R12: timing of irq_o
        wr(4'd1, 32'h0000_0001);
        settle();
        irq_int_n[31] = 1'b0;
        #0.5;
        chk({31'd0, irq_o}, 32'd0, "R12 no combinational path");
        @(posedge clk); @(negedge clk);
        chk({31'd0, irq_o}, 32'd1, "R12 one clock latency");
        chk({25'd0, vec_o}, 32'd63, "R12 vector with irq");
        irq_int_n = '1;
        @(posedge clk); @(negedge clk);
        chk({31'd0, irq_o}, 32'd0, "R12 drop one clock");
        wr(4'd1, 32'd0);

        // R4 R5 R6: edge pins
        wr(4'd2, 32'hFF00_0000);
        for (int k = 0; k < 8; k++) begin
            wr(4'd3, 32'd1 << (15 - k));
            rd(4'd3, d); chk(d, 32'd1 << (15 - k), "R4 sense bit position");
            irq_ext_n[k] = 1'b0;
            settle();
            chk({25'd0, vec_o}, 16 + k, "R5 falling edge latched");
            irq_ext_n[k] = 1'b1;
            settle();
            chk({25'd0, vec_o}, 16 + k, "R5 flag held after release");
            rd(4'd4, d); chk(d, 32'h8000_0000 >> k, "R6 edge flag read");
            wr(4'd4, ~(32'h8000_0000 >> k));
            settle();
            rd(4'd4, d); chk(d, 32'h8000_0000 >> k, "R5 zero write no effect");
            wr(4'd4, 32'h8000_0000 >> k);
            settle();
            chk({25'd0, vec_o}, 32'd0, "R5 flag cleared");
            rd(4'd4, d); chk(d, 32'd0, "R5 pending clear read");
            // level pin: remaining pins level, held low
            lvl = 8'd1 << ((k + 1) % 8);
            irq_ext_n = ~lvl;
            settle();
            rd(4'd4, d); chk(d, 32'h8000_0000 >> ((k + 1) % 8), "R6 level state read");
            wr(4'd4, 32'hFF00_0000);
            settle();
            rd(4'd4, d); chk(d, 32'h8000_0000 >> ((k + 1) % 8), "R6 level ignores clear");
            chk({25'd0, vec_o}, 16 + ((k + 1) % 8), "R4 level pin delivered");
            irq_ext_n = '1;
            settle();
        end
        wr(4'd3, 32'd0);

        // R9: pins above groups
        wr(4'd1, 32'hFFFF_FFFF);
        irq_int_n = 32'h0000_0000;
        irq_ext_n = 8'b0111_1111;
        settle();
        chk({25'd0, vec_o}, 32'd23, "R9 pin above internal");
        irq_ext_n = '1;
        settle();
        chk({25'd0, vec_o}, 32'd32, "R9 group A first");
        irq_int_n = 32'h0000_FFFF;
        settle();
        chk({25'd0, vec_o}, 32'd48, "R9 group C over D");
        irq_int_n = '1;

        // R7 R8 R9 R10: pseudo-random sweep
        for (int it = 0; it < 400; it++) begin
            logic [31:0] r0, r1, r2, sel;
            logic [7:0]  en8;
            sh_ien = rnd(seed);
            r0 = rnd(seed); r1 = rnd(seed);
            sel = rnd(seed);
            sh_een = (sel[1:0] == 2'd0) ? (rnd(seed) & 32'hFF00_0000) : 32'd0;
            for (int g = 0; g < 4; g++) sh_prio[g] = rnd(seed);
            r2 = rnd(seed);
            case (sel[4:2])
                3'd0, 3'd1: sh_ovr = 7'd0;
                3'd2:       sh_ovr = 7'(16 + r2[2:0]);
                3'd3:       sh_ovr = 7'(100 + r2[3:0]);
                default:    sh_ovr = 7'(32 + r2[4:0]);
            endcase
            wr(4'd1, sh_ien);
            wr(4'd2, sh_een);
            for (int g = 0; g < 4; g++) wr(4'(8 + g), sh_prio[g]);
            wr(4'd0, {1'b0, sh_ovr, 24'd0});
            irq_int_n = sel[5] ? ~(r0 & r1) : ~(r0 & r1 & rnd(seed));
            en8 = rnd(seed);
            irq_ext_n = ~(en8 & r0[7:0]);
            settle();
            chk({25'd0, vec_o},
                {25'd0, model(sh_ien, sh_een, ~irq_ext_n, irq_int_n, sh_prio, sh_ovr)},
                "R7 R8 R9 R10 sweep vector");
            chk({31'd0, irq_o}, {31'd0, (vec_o != 7'd0)}, "R12 sweep irq");
            if (it % 50 == 0) begin
                rd(4'd9, d); chk(d, sh_prio[1] & 32'hFFF0_FFF0, "R7 slot field readback");
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule